// File: doc/BRIEF.md
# Character Pattern RAM Loader

This block sits behind the byte deserializer of a dot-matrix display controller and fills a small table of user-defined character glyphs. Each glyph is a 5-column by 7-row dot pattern, held as one 35-bit word. The incoming stream begins with a command byte that picks the first table slot. Data bytes follow, one per column. The block gathers them into a working pattern and commits it once the fifth column of a group arrives.

Bits are spread across the columns with a stride of five. Bit j of the byte for column k becomes dot k+5j of the pattern, and the top bit of every byte is dropped. The slot pointer steps up after each committed glyph and wraps at the end of the table. A single long burst can therefore rewrite every slot, then carry on from slot zero. A separate combinational read port lets the scan logic, or a bench, look at any slot.

Top module: `glyph_loader`

## Requirements
- R1: After reset the write enable is low, the column position is 0 and the slot pointer is 0, so five data bytes sent with no command byte write slot 0.
- R2: A valid byte with the start marker high is a command byte. Its bits [3:0] load the slot pointer, and bits [7:4] have no effect.
- R3: Bit j (0..6) of the data byte for column k (0..4) lands in pattern bit 5*j+k of the committed word.
- R4: Bit 7 of a data byte has no effect on the stored pattern.
- R5: A write pulse occurs exactly once per complete group of five data bytes. It is one cycle wide and rises on the cycle after the fifth byte is accepted. No write is made for a group of fewer than five bytes.
- R6: The write carries the slot of its group. Each committed group advances the slot by one, and slot 15 is followed by slot 0.
- R7: A command byte that arrives part-way through a group drops the collected columns. The next data byte is treated as column 0.
- R8: A cycle with the valid input low changes nothing, whatever the start marker and data inputs carry.
- R9: One cycle after a write pulse, the read port returns the written pattern for that slot. Slots that were not written keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_start | input | 1 | Marks the strobed byte as a command byte |
| in_byte | input | 8 | Incoming byte |
| wr_en | output | 1 | Pattern RAM write pulse |
| wr_addr | output | 4 | Slot being written |
| wr_data | output | 35 | Pattern being written |
| rd_addr | input | 4 | Read slot select |
| rd_data | output | 35 | Pattern stored at rd_addr |

## Verification
The bench drives a burst of seventeen glyphs that runs past slot 15. A pointer that saturates, or one that fails to wrap, would put the last glyph in the wrong slot. It sets bit 7 on some data bytes, sets the upper nibble of command bytes, and leaves idle cycles with the start marker and junk data showing. A decoder that read any of these would corrupt a pattern or move the pointer. It breaks off a group with a fresh command and then reads back the slot that the partial group aimed at. A design that kept the stale column count would misalign every later glyph, and one that wrote early would clobber that slot.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int GLYPH_COLS = 5;
  localparam int GLYPH_ROWS = 7;
  localparam int GLYPH_DOTS = GLYPH_COLS * GLYPH_ROWS;
  localparam int SLOT_W     = 4;
  localparam int BYTE_W     = 8;
  localparam int COL_W      = $clog2(GLYPH_COLS);

  typedef logic [GLYPH_DOTS-1:0] glyph_t;

  // Drop one column byte into a pattern: byte bit j goes to dot col + COLS*j.
  function automatic glyph_t merge_column(input glyph_t pat,
                                          input logic [COL_W-1:0] col,
                                          input logic [BYTE_W-1:0] b);
    glyph_t r;
    r = pat;
    for (int j = 0; j < GLYPH_ROWS; j++) begin
      r[int'(col) + GLYPH_COLS * j] = b[j];
    end
    return r;
  endfunction
endpackage

// File: rtl/glyph_assembler.sv
module glyph_assembler
  import glyph_pkg::*;
#(
  parameter int SLOTS_W = SLOT_W,
  parameter int DW      = BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_start,
  input  logic [DW-1:0]          in_byte,
  output logic                   wr_en,
  output logic [SLOTS_W-1:0]     wr_addr,
  output glyph_t                 wr_data,
  output logic [COL_W-1:0]       col_idx,
  output logic                   group_done
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(GLYPH_COLS - 1);

  logic               cmd_hit;
  logic               data_hit;
  logic [SLOTS_W-1:0] slot_q;
  glyph_t             shadow_q;
  glyph_t             next_pat;

  assign cmd_hit    = in_valid & in_start;
  assign data_hit   = in_valid & ~in_start;
  assign group_done = data_hit & (col_idx == LAST_COL);
  assign next_pat   = merge_column(shadow_q, col_idx, in_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_idx  <= '0;
      slot_q   <= '0;
      shadow_q <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= group_done;
      if (cmd_hit) begin
        slot_q  <= in_byte[SLOTS_W-1:0];
        col_idx <= '0;
      end else if (data_hit) begin
        shadow_q <= next_pat;
        if (group_done) begin
          col_idx <= '0;
          slot_q  <= slot_q + 1'b1;
          wr_addr <= slot_q;
          wr_data <= next_pat;
        end else begin
          col_idx <= col_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/glyph_ram.sv
module glyph_ram
  import glyph_pkg::*;
#(
  parameter int AW = SLOT_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  glyph_t        wdata,
  input  logic [AW-1:0] raddr,
  output glyph_t        rdata
);
  localparam int DEPTH = 1 << AW;

  glyph_t entry [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(i)) entry[i] <= wdata;
    end
  end

  assign rdata = entry[raddr];
endmodule

// File: rtl/glyph_loader.sv
module glyph_loader
  import glyph_pkg::*;
#(
  parameter int ADDR_W = SLOT_W,
  parameter int DOTS   = GLYPH_DOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [7:0]        in_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DOTS-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DOTS-1:0]   rd_data
);
  logic [COL_W-1:0] col_idx;
  logic             group_done;
  glyph_t           pat_w;
  glyph_t           pat_r;

  glyph_assembler #(.SLOTS_W(ADDR_W), .DW(8)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .in_byte    (in_byte),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (pat_w),
    .col_idx    (col_idx),
    .group_done (group_done)
  );

  glyph_ram #(.AW(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (pat_w),
    .raddr (rd_addr),
    .rdata (pat_r)
  );

  assign wr_data = pat_w;
  assign rd_data = pat_r;
endmodule

// File: rtl/glyph_loader_chk.sv
module glyph_loader_chk #(
  parameter int ADDR_W = 4,
  parameter int DOTS   = 35,
  parameter int COLS   = 5,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_start,
  input logic [7:0]        in_byte,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DOTS-1:0]   wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DOTS-1:0]   rd_data,
  input logic [CW-1:0]     col_idx,
  input logic              group_done
);
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);

  // Independent byte counter and slot tracker.
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] grp_slot;
  logic [ADDR_W-1:0] done_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      grp_slot  <= '0;
      done_slot <= '0;
    end else if (in_valid && in_start) begin
      cnt      <= '0;
      grp_slot <= in_byte[ADDR_W-1:0];
    end else if (in_valid) begin
      if (cnt == LAST) begin
        cnt       <= '0;
        grp_slot  <= grp_slot + 1'b1;
        done_slot <= grp_slot;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_write_on_fifth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en == $past(in_valid && !in_start && cnt == LAST));

  p_done_matches_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    group_done == (in_valid && !in_start && cnt == LAST));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_slot_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr == done_slot);

  p_col_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_idx <= LAST);

  p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_addr == $past(wr_addr)) |-> rd_data == $past(wr_data));
endmodule

bind glyph_loader glyph_loader_chk #(
  .ADDR_W(ADDR_W), .DOTS(DOTS), .COLS(glyph_pkg::GLYPH_COLS), .CW(glyph_pkg::COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
  .in_byte(in_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .col_idx(col_idx), .group_done(group_done)
);

// File: tb/glyph_loader_test.sv
module glyph_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_start = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [34:0] wr_data;
  logic [3:0]  rd_addr = 4'h0;
  logic [34:0] rd_data;

  always #10 clk = ~clk;

  glyph_loader uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_byte(in_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct { logic [3:0] a; logic [34:0] d; } exp_t;
  exp_t        sb[$];
  logic [34:0] model [16];
  logic [3:0]  cur_slot = 4'h0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  task automatic put(input bit v, input bit s, input logic [7:0] b);
    @(negedge clk);
    in_valid = v; in_start = s; in_byte = b;
  endtask

  // Idle with junk on start/data: must be ignored (R8).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b1, 8'hC0 ^ 8'(i));
  endtask

  task automatic send_cmd(input logic [7:0] b);
    put(1'b1, 1'b1, b);
    cur_slot = b[3:0];
  endtask

  // Build column bytes from the pattern: byte k bit j = dot 5*j+k (R3).
  task automatic send_glyph(input logic [34:0] p, input bit b7, input bit gaps, input int ncols);
    for (int k = 0; k < ncols; k++) begin
      logic [7:0] b;
      for (int j = 0; j < 7; j++) b[j] = p[5*j + k];
      b[7] = b7;
      if (gaps) idle(1);
      if (k == 4) begin
        sb.push_back('{cur_slot, p});
        model[cur_slot] = p;
        cur_slot = cur_slot + 4'd1;
      end
      put(1'b1, 1'b0, b);
    end
  endtask

  task automatic check_read(input logic [3:0] a, input string tag);
    @(negedge clk); rd_addr = a;
    @(negedge clk);
    checks++;
    if (rd_data !== model[a]) begin
      errors++;
      $display("FAIL %s read slot %0d actual %h expected %h", tag, a, rd_data, model[a]);
    end
  endtask

  // Monitor: pops the scoreboard on every write pulse.
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected write slot %0d actual %h expected none", wr_addr, wr_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (wr_addr !== e.a || wr_data !== e.d) begin
          errors++;
          $display("FAIL R3/R6 write actual %0d:%h expected %0d:%h", wr_addr, wr_data, e.a, e.d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (wr_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset wr_en actual %b expected 0", wr_en);
    end
    rst_n = 1'b1;

    // R1: no command, pointer starts at 0
    send_glyph(35'h5_A5A5_A5A5, 1'b0, 1'b0, 5);
    // R2: upper nibble ignored -> slot 3; R4: bit 7 set
    send_cmd(8'hF3);
    send_glyph(35'h1_2345_6789, 1'b0, 1'b0, 5);
    send_glyph(35'h7_FFFF_0001, 1'b1, 1'b0, 5);
    // R6 wrap and R8 gaps
    send_cmd(8'h0E);
    for (int g = 0; g < 4; g++)
      send_glyph(35'h3_0F0F_1234 ^ 35'(g * 32'h0101_0BAD), 1'b0, 1'b1, 5);
    // R7: partial group dropped
    send_cmd(8'h05);
    send_glyph(35'h2_DEAD_BEEF, 1'b0, 1'b0, 5);
    send_cmd(8'h85);
    send_glyph(35'h4_1111_2222, 1'b1, 1'b0, 3);
    send_cmd(8'h0A);
    send_glyph(35'h6_CAFE_F00D, 1'b0, 1'b0, 5);
    idle(3);
    check_read(4'h5, "R7");
    check_read(4'h0, "R9");
    check_read(4'h4, "R4");
    // R6: long burst of 17 glyphs rewrites all and overwrites slot 0
    send_cmd(8'h00);
    for (int g = 0; g < 17; g++)
      send_glyph({3'b101, 32'h9E37_79B9 * 32'(g + 1)}, g[0], 1'b0, 5);
    idle(3);
    for (int a = 0; a < 16; a++) check_read(4'(a), "R9");
    idle(2);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R5 pending writes actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule